// File: doc/BRIEF.md
# Dual-Clock Selectable Watchdog Timer

This block watches for a runaway program. A free-running counter advances on count pulses from one of two clock sources: a slow internal ring oscillator or the fast high-speed system clock. If software does not restart the counter before the selected period ends, the block raises a one-cycle internal reset request. Each clock source has its own set of eight power-of-two periods. With the default parameters these are 2^11 to 2^18 slow-clock periods, or 2^13 to 2^20 fast-clock periods. For example, at a 480 kHz ring clock the shortest period is about 4.27 ms, and at a 10 MHz fast clock it is 819.2 µs.

The source and the period come from two configuration pins, which behave like an option byte. The block samples them on power-on reset and again at every watchdog reset request. Changes on the pins between those moments have no effect. Software restarts the counter by presenting a key byte on the restart port. Any other byte there is treated as a fault and causes an immediate reset request. Both clock sources reach the block as single-cycle count enables in the block's clock domain.

The block also holds an 8-bit reset-cause register. Bit 4 of this register records that a watchdog reset request occurred. The bit survives later watchdog requests. Software clears it by writing a 0 to bit 4, and power-on reset clears the whole register.

Top module: `dualclk_wdog`

## Requirements
- R1: While `rst` is high and after it falls, `wdog_req` is 0 and `cause_q` is 8'h00. The counter starts from zero, and the configuration is taken from `cfg_src`/`cfg_sel`.
- R2: With `cfg_src`=0 (slow source), the N-th `slow_tick` pulse after a restart causes `wdog_req`=1 in the cycle after the edge that sampled it. N = 2^(SLOW_MIN+`cfg_sel`), where `cfg_sel`=0 is the shortest period and 7 the longest. Fewer than N pulses give no request.
- R3: With `cfg_src`=1 (fast source), the same rule holds for `fast_tick` with N = 2^(FAST_MIN+`cfg_sel`).
- R4: Pulses from the source that is not selected never advance the counter.
- R5: `kick_valid` with `kick_key` equal to KEY (default 8'hAC) clears the counter, and counting restarts from zero. A correct restart in the same cycle as the completing count pulse prevents the request.
- R6: `kick_valid` with any other `kick_key` value raises `wdog_req` in the next cycle.
- R7: `wdog_req` never stays high for two consecutive cycles. During the cycle it is high, count pulses and restart strobes are ignored, and the counter restarts from zero.
- R8: `cfg_src`/`cfg_sel` are sampled only during reset and at the edge that raises `wdog_req`. Changes at any other time do not alter the running period.
- R9: Every watchdog request sets bit 4 of `cause_q`. The other seven bits always read 0, and bit 4 stays set across later requests and restarts.
- R10: A write with `cause_wdata` bit 4 = 0 clears bit 4, and a write with bit 4 = 1 changes nothing. If a request and a clearing write fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_src | input | 1 | Configuration: 0 slow ring source, 1 fast system source |
| cfg_sel | input | 3 | Configuration: period select, 0 shortest |
| slow_tick | input | 1 | Count enable from the slow ring oscillator |
| fast_tick | input | 1 | Count enable from the fast system clock |
| kick_valid | input | 1 | Restart strobe |
| kick_key | input | 8 | Byte presented with the restart strobe |
| cause_wr | input | 1 | Write strobe for the reset-cause register |
| cause_wdata | input | 8 | Write data for the reset-cause register |
| cause_q | output | 8 | Reset-cause register, watchdog at bit 4 |
| wdog_req | output | 1 | One-cycle internal reset request |

## Verification
The hardest situation to reach from the ports is a collision in a single cycle, such as a completing count pulse arriving together with a clearing write to the cause register, or a second bad key arriving in the cycle the request is already high. To create these, the bench brings the counter to one pulse short of its period and then drives both inputs for the same edge. The bench also changes the configuration pins in the middle of a period and checks that the old period still ends the count, and that the new one applies only after the request. The long periods are reached by overriding the minimum exponents with small values, so that the longest code of both sources can be counted out completely.

// File: rtl/dualclk_wdog_pkg.sv
package dualclk_wdog_pkg;

    localparam int unsigned SEL_W    = 3;
    localparam int unsigned SEL_SPAN = 1 << SEL_W;
    localparam int unsigned CAUSE_W  = 8;
    localparam int unsigned WDOG_BIT = 4;
    localparam int unsigned KEY_W    = 8;

    typedef enum logic {
        SRC_SLOW = 1'b0,
        SRC_FAST = 1'b1
    } wdog_src_e;

    typedef struct packed {
        wdog_src_e        src;
        logic [SEL_W-1:0] sel;
    } wdog_cfg_t;

    function automatic int unsigned period_exp(
        input wdog_cfg_t   cfg,
        input int unsigned slow_min,
        input int unsigned fast_min
    );
        int unsigned base;
        base = (cfg.src == SRC_FAST) ? fast_min : slow_min;
        return base + int'(cfg.sel);
    endfunction

    function automatic int unsigned max_exp(
        input int unsigned slow_min,
        input int unsigned fast_min
    );
        return ((slow_min > fast_min) ? slow_min : fast_min) + SEL_SPAN - 1;
    endfunction

endpackage

// File: rtl/wdog_cfg_latch.sv
module wdog_cfg_latch
    import dualclk_wdog_pkg::*;
#(
    parameter int unsigned SLOW_MIN = 11,
    parameter int unsigned FAST_MIN = 13,
    parameter int unsigned EXP_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  wdog_cfg_t        cfg_pin,
    output wdog_cfg_t        cfg_q,
    output logic [EXP_W-1:0] exp_q
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cfg_q <= cfg_pin;
        end
    end

    assign exp_q = EXP_W'(period_exp(cfg_q, SLOW_MIN, FAST_MIN));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 21,
    parameter int unsigned EXP_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic [EXP_W-1:0] exp,
    output logic             ovf
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    assign cnt_nxt = cnt_q + 1'b1;
    assign ovf     = tick && !clr && cnt_nxt[exp];

    always_ff @(posedge clk) begin
        if (rst || clr || ovf) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
        end
    end

    // R2
    cnt_below_limit_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_q[exp]);

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

    // R4
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_cause_flag.sv
module wdog_cause_flag
    import dualclk_wdog_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               set,
    input  logic               wr,
    input  logic [CAUSE_W-1:0] wdata,
    output logic [CAUSE_W-1:0] cause
);

    logic wd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wd_q <= 1'b0;
        end else if (set) begin
            wd_q <= 1'b1;
        end else if (wr && !wdata[WDOG_BIT]) begin
            wd_q <= 1'b0;
        end
    end

    always_comb begin
        cause           = '0;
        cause[WDOG_BIT] = wd_q;
    end

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> cause[WDOG_BIT]);

    // R10
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!set && !(wr && !wdata[WDOG_BIT])) |=> $stable(cause));

endmodule

// File: rtl/dualclk_wdog.sv
module dualclk_wdog
    import dualclk_wdog_pkg::*;
#(
    parameter int unsigned SLOW_MIN = 11,
    parameter int unsigned FAST_MIN = 13,
    parameter logic [7:0]  KEY      = 8'hAC
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_src,
    input  logic [2:0] cfg_sel,
    input  logic       slow_tick,
    input  logic       fast_tick,
    input  logic       kick_valid,
    input  logic [7:0] kick_key,
    input  logic       cause_wr,
    input  logic [7:0] cause_wdata,
    output logic [7:0] cause_q,
    output logic       wdog_req
);

    localparam int unsigned MAX_EXP = max_exp(SLOW_MIN, FAST_MIN);
    localparam int unsigned CNT_W   = MAX_EXP + 1;
    localparam int unsigned EXP_W   = $clog2(MAX_EXP + 1);

    wdog_cfg_t        cfg_pin;
    wdog_cfg_t        cfg_q;
    logic [EXP_W-1:0] exp_q;
    logic             req_q;
    logic             src_tick;
    logic             cnt_tick;
    logic             cnt_clr;
    logic             ovf;
    logic             key_ok;
    logic             key_bad;
    logic             fire;

    assign cfg_pin.src = wdog_src_e'(cfg_src);
    assign cfg_pin.sel = cfg_sel;

    assign src_tick = (cfg_q.src == SRC_FAST) ? fast_tick : slow_tick;
    assign cnt_tick = src_tick && !req_q;
    assign key_ok   = kick_valid && !req_q && (kick_key == KEY);
    assign key_bad  = kick_valid && !req_q && (kick_key != KEY);
    assign cnt_clr  = req_q || (kick_valid && !req_q);
    assign fire     = !req_q && (ovf || key_bad);

    wdog_cfg_latch #(
        .SLOW_MIN (SLOW_MIN),
        .FAST_MIN (FAST_MIN),
        .EXP_W    (EXP_W)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (fire),
        .cfg_pin (cfg_pin),
        .cfg_q   (cfg_q),
        .exp_q   (exp_q)
    );

    wdog_counter #(
        .CNT_W (CNT_W),
        .EXP_W (EXP_W)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (cnt_tick),
        .clr  (cnt_clr),
        .exp  (exp_q),
        .ovf  (ovf)
    );

    wdog_cause_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .set   (fire),
        .wr    (cause_wr),
        .wdata (cause_wdata),
        .cause (cause_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else begin
            req_q <= fire;
        end
    end

    assign wdog_req = req_q;

    // R7
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_req |=> !wdog_req);

    // R6
    bad_key_chk: assert property (@(posedge clk) disable iff (rst)
        (kick_valid && (kick_key != KEY) && !wdog_req) |=> wdog_req);

    // R5
    good_key_chk: assert property (@(posedge clk) disable iff (rst)
        (kick_valid && (kick_key == KEY) && !wdog_req) |=> !wdog_req);

endmodule

// File: tb/dualclk_wdog_tb.sv
module dualclk_wdog_tb;

    localparam int unsigned SMIN = 2;
    localparam int unsigned FMIN = 3;
    localparam logic [7:0]  KEY  = 8'hAC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_src = 1'b0;
    logic [2:0] cfg_sel = 3'd0;
    logic       slow_tick = 1'b0;
    logic       fast_tick = 1'b0;
    logic       kick_valid = 1'b0;
    logic [7:0] kick_key = 8'h00;
    logic       cause_wr = 1'b0;
    logic [7:0] cause_wdata = 8'h00;
    logic [7:0] cause_q;
    logic       wdog_req;

    typedef struct {
        string      tag;
        logic       req;
        logic [7:0] cause;
    } exp_item_t;

    exp_item_t sb_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    dualclk_wdog #(.SLOW_MIN(SMIN), .FAST_MIN(FMIN), .KEY(KEY)) u_dut (
        .clk(clk), .rst(rst), .cfg_src(cfg_src), .cfg_sel(cfg_sel),
        .slow_tick(slow_tick), .fast_tick(fast_tick),
        .kick_valid(kick_valid), .kick_key(kick_key),
        .cause_wr(cause_wr), .cause_wdata(cause_wdata),
        .cause_q(cause_q), .wdog_req(wdog_req)
    );

    // monitor: compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                n_tests++;
                if (wdog_req !== it.req || cause_q !== it.cause) begin
                    n_fail++;
                    $display("FAIL %s: req=%0b cause=%02h expected req=%0b cause=%02h",
                             it.tag, wdog_req, cause_q, it.req, it.cause);
                end
            end
        end
    end

    task automatic expect_out(input string tag, input logic req, input logic [7:0] cause);
        exp_item_t it;
        it.tag = tag; it.req = req; it.cause = cause;
        sb_q.push_back(it);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic por(input logic src, input logic [2:0] sel);
        cfg_src = src; cfg_sel = sel; rst = 1'b1;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic tickn(input bit fast, input int n);
        for (int i = 0; i < n; i++) begin
            if (fast) fast_tick = 1'b1; else slow_tick = 1'b1;
            step();
            slow_tick = 1'b0; fast_tick = 1'b0;
        end
    endtask

    task automatic kick(input logic [7:0] k);
        kick_valid = 1'b1; kick_key = k;
        step();
        kick_valid = 1'b0;
    endtask

    task automatic wr_cause(input logic [7:0] d);
        cause_wr = 1'b1; cause_wdata = d;
        step();
        cause_wr = 1'b0;
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog: run hung, cycles=%0d expected < 100000", cyc);
                report();
            end
        end
    end

    initial begin
        real t_ms;
        real t_us;
        // sanity figures for the default exponents (R2, R3)
        t_ms = (2.0 ** 11) / 480.0e3 * 1.0e3;
        t_us = (2.0 ** 13) / 10.0e6 * 1.0e6;
        n_tests++;
        if (t_ms < 4.26 || t_ms > 4.28) begin
            n_fail++; $display("FAIL R2 figure: %f ms expected 4.27", t_ms);
        end
        n_tests++;
        if (t_us < 819.1 || t_us > 819.3) begin
            n_fail++; $display("FAIL R3 figure: %f us expected 819.2", t_us);
        end

        // R1 reset state, slow source, shortest period (4 pulses)
        por(1'b0, 3'd0);
        expect_out("R1 after reset", 1'b0, 8'h00);

        // R2 slow period boundary
        tickn(0, 3);  expect_out("R2 slow one short", 1'b0, 8'h00);
        tickn(0, 1);  expect_out("R2 slow overflow", 1'b1, 8'h10);
        step();       expect_out("R7 pulse ends", 1'b0, 8'h10);

        // R4 fast pulses ignored while slow selected
        tickn(1, 40); expect_out("R4 fast ignored", 1'b0, 8'h10);

        // R8 pin change mid period has no effect until the request
        tickn(0, 3);
        cfg_src = 1'b1; cfg_sel = 3'd1;
        tickn(0, 1);  expect_out("R8 old period kept", 1'b1, 8'h10);
        step();
        tickn(1, 15); expect_out("R3 fast sel1 one short", 1'b0, 8'h10);
        tickn(0, 10); expect_out("R4 slow ignored", 1'b0, 8'h10);
        tickn(1, 1);  expect_out("R3 fast sel1 overflow", 1'b1, 8'h10);
        step();

        // R5 correct key restarts the count
        tickn(1, 15);
        kick(KEY);    expect_out("R5 good key", 1'b0, 8'h10);
        tickn(1, 15); expect_out("R5 restarted short", 1'b0, 8'h10);
        tickn(1, 1);  expect_out("R5 restarted overflow", 1'b1, 8'h10);
        step();

        // R5 good key together with completing pulse
        tickn(1, 15);
        fast_tick = 1'b1;
        kick(KEY);
        fast_tick = 1'b0;
        expect_out("R5 key beats pulse", 1'b0, 8'h10);

        // R10 writes
        wr_cause(8'h10); expect_out("R10 write one no effect", 1'b0, 8'h10);
        wr_cause(8'hEF); expect_out("R10 write zero clears", 1'b0, 8'h00);

        // R6 bad key, R9 flag set
        kick(8'h53);  expect_out("R6 bad key", 1'b1, 8'h10);
        kick(8'h00);  expect_out("R7 kick during request ignored", 1'b0, 8'h10);
        kick(8'h5A);  expect_out("R6 bad key again", 1'b1, 8'h10);
        step();       expect_out("R9 flag survives", 1'b0, 8'h10);
        tickn(1, 15); expect_out("R7 count restarted", 1'b0, 8'h10);
        kick(KEY);

        // R10 set wins over clearing write
        wr_cause(8'h00); expect_out("R10 cleared", 1'b0, 8'h00);
        tickn(1, 15);
        fast_tick = 1'b1;
        wr_cause(8'h00);
        fast_tick = 1'b0;
        expect_out("R10 set wins", 1'b1, 8'h10);
        step();

        // R1 power-on clears flag; long periods
        por(1'b1, 3'd7);
        expect_out("R1 flag cleared by reset", 1'b0, 8'h00);
        tickn(1, 1023); expect_out("R3 fast sel7 one short", 1'b0, 8'h00);
        tickn(1, 1);    expect_out("R3 fast sel7 overflow", 1'b1, 8'h10);
        por(1'b0, 3'd7);
        tickn(0, 511);  expect_out("R2 slow sel7 one short", 1'b0, 8'h00);
        tickn(0, 1);    expect_out("R2 slow sel7 overflow", 1'b1, 8'h10);
        por(1'b0, 3'd3);
        tickn(0, 31);   expect_out("R2 slow sel3 one short", 1'b0, 8'h00);
        tickn(0, 1);    expect_out("R2 slow sel3 overflow", 1'b1, 8'h10);

        step(); step();
        done = 1'b1;
        report();
    end

endmodule